// File: doc/BRIEF.md
# Masked Watchpoint Comparator Unit

This block watches the access stream of a processor core with four comparators. Each comparator holds a 32-bit reference, a 4-bit count of low address bits to ignore, a 4-bit action code and a range bit. On every cycle in which the access strobe is high, each comparator checks the presented access. The access can be an instruction execution, which is checked against the PC, or a data read or write, which is checked against the data address. Depending on the action code, a match raises a watchpoint request, pulses a trace trigger, or asks for a trace record that carries the PC, the low address half and/or the data value. Packet serialization and halting the core are left to neighbouring blocks.

Comparator 0 can compare its reference against the free-running cycle count instead of an address. Comparator 1 can switch to data-value matching. In that mode it fires only when one of up to two linked comparators has matched the address. Those linked comparators then serve only as address matchers. Every comparator has a sticky matched flag, which the register file clears by pulsing a read-clear line when it reads that comparator's action register.

The flag of each comparator is a two-state machine. FLAG_CLEAR moves to FLAG_HELD on transition SET, when the comparator's action fires. FLAG_HELD returns to FLAG_CLEAR on transition CLEAR, when a read-clear arrives without a new firing. FLAG_HELD stays put on transition KEEP, when a read-clear and a firing coincide or no read-clear arrives. FLAG_CLEAR stays put on transition IDLE otherwise. All outputs are registered one cycle behind the access strobe.

Top module: `watch_cmp_unit`

## Requirements
- R1: After reset every output is 0: no watchpoint, trigger or emit, a zero payload, and all matched flags clear.
- R2: A data access matches when the address and the reference agree once their low k bits are ignored, where k is the larger of the comparator's mask value and the access size code (0 byte, 1 halfword, 2 word). A word access at 0x100 therefore matches a reference of 0x103. PC compares ignore only the mask bits.
- R3: Action codes 4 to 7 raise `watch_req` on, respectively, a PC match, a data read match, a data write match and a data read-or-write match. The request appears in the cycle after the access.
- R4: Action codes 8 to 11 pulse `trig_pulse` under the same four qualifiers as R3, in the same order.
- R5: Emit codes select a direction and a payload. Codes 1, 2 and 3 fire on read or write and carry PC, data, or PC plus data. Codes 12 and 13 carry data on reads and on writes. Codes 14 and 15 carry PC plus data on reads and on writes. `emit_valid[i]` is set with at least one of the payload-select bits of comparator i. The payload registers capture PC, address[15:0] and data on every valid access.
- R6: With the range bit set, every emit code replaces the PC with the low address half. Codes 12 and 13 then carry only the address half, with no data.
- R7: A faulted access drops the data part of an emit while keeping the PC part. The PC part is carried only when `acc_first` marks the first beat of a burst. An emit whose payload is left empty does not fire.
- R8: `matched[i]` is set in the cycle after comparator i fires and stays set until `flag_rd_clr[i]` is pulsed. A read-clear in the same cycle as a new firing leaves the flag set.
- R9: With `cfg_cyc_match` set, comparator 0 compares `cycle_count` (mask applied) with its reference on every cycle, whether or not an access is present. Only its watch and trigger codes act in this mode; the direction qualifier is ignored.
- R10: With `cfg_dv_enable` set, comparator 1 fires on a non-faulting data access in its code's direction when its reference equals the data at the width set by `cfg_dv_size` (0 byte, 1 halfword, 2 or 3 word). The access address must also match at least one linked comparator. A link index of 1 or of 4 or more names no comparator, and PC-type codes never fire in this mode.
- R11: While data-value mode is on, comparators named by `cfg_link_a` or `cfg_link_b` neither act nor set their matched flags.
- R12: Action code 0 disables a comparator: it never acts and never sets its flag.
- R13: Without a valid access, and with cycle matching off, no output event occurs and no flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_instr | input | 1 | 1: instruction execution (PC compare), 0: data access |
| acc_write | input | 1 | Data access is a write |
| acc_size | input | 2 | Data access size code, 0 byte, 1 halfword, 2 word |
| acc_fault | input | 1 | Data access faulted |
| acc_first | input | 1 | First beat of a burst |
| acc_pc | input | 32 | PC of the instruction |
| acc_addr | input | 32 | Data address |
| acc_data | input | 32 | Data value |
| cycle_count | input | 32 | Free-running cycle count |
| cfg_ref | input | 128 | References, comparator i in bits [32i+31:32i] |
| cfg_mask | input | 16 | Ignored low-bit counts, 4 bits each |
| cfg_func | input | 16 | Action codes, 4 bits each |
| cfg_range | input | 4 | Emit address half instead of PC |
| cfg_cyc_match | input | 1 | Comparator 0 compares against the cycle count |
| cfg_dv_enable | input | 1 | Comparator 1 data-value mode |
| cfg_dv_size | input | 2 | Data-value width code |
| cfg_link_a | input | 4 | First linked comparator index |
| cfg_link_b | input | 4 | Second linked comparator index |
| flag_rd_clr | input | 4 | Read-clear pulses for the matched flags |
| watch_req | output | 1 | Watchpoint request |
| trig_pulse | output | 1 | Trace trigger pulse |
| emit_valid | output | 4 | Emit request per comparator |
| emit_pc_sel | output | 4 | Emit carries the PC |
| emit_addr_sel | output | 4 | Emit carries address[15:0] |
| emit_data_sel | output | 4 | Emit carries the data value |
| emit_pc | output | 32 | Captured PC |
| emit_addr_lo | output | 16 | Captured address[15:0] |
| emit_data | output | 32 | Captured data value |
| matched | output | 4 | Sticky matched flags |

## Verification
A wrong ignore count or direction decode shows up as a missing or extra `watch_req`, `trig_pulse` or `emit_valid` bit in the cycle after the offending access. The faulty bit also latches into `matched`, so it stays visible at the ports until the next read-clear. A flag machine stuck in FLAG_HELD, or one that loses a coinciding firing, differs from the reference model on the first cycle after a read-clear. A broken link or override decode in data-value mode fires comparator 1 or a linked comparator on a single access, and that too is visible one cycle later. The bench's reference model is evaluated every cycle, so any such divergence is reported on the edge where it first appears.

// File: rtl/wcu_pkg.sv
package wcu_pkg;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_WATCH,
        ACT_TRIG,
        ACT_EMIT
    } act_e;

    // Order follows the low two bits of codes 4..11
    typedef enum logic [1:0] {
        SEL_PC,
        SEL_RD,
        SEL_WR,
        SEL_RW
    } sel_e;

    typedef struct packed {
        act_e act;
        sel_e sel;
        logic want_pc;
        logic want_off;
        logic want_dat;
    } fdec_t;

    typedef enum logic {
        FLAG_CLEAR,
        FLAG_HELD
    } flag_e;

endpackage

// File: rtl/wcu_func_dec.sv
module wcu_func_dec
    import wcu_pkg::*;
#(
    parameter int FW = 4
) (
    input  logic [FW-1:0] code,
    input  logic          rng,
    output fdec_t         dec
);

    always_comb begin
        dec = '0;
        unique case (code) inside
            4'd0: dec.act = ACT_NONE;
            [4'd4:4'd7]: begin
                dec.act = ACT_WATCH;
                dec.sel = sel_e'(code[1:0]);
            end
            [4'd8:4'd11]: begin
                dec.act = ACT_TRIG;
                dec.sel = sel_e'(code[1:0]);
            end
            4'd1: begin
                dec.act      = ACT_EMIT;
                dec.sel      = SEL_RW;
                dec.want_pc  = ~rng;
                dec.want_off = rng;
            end
            4'd2: begin
                dec.act      = ACT_EMIT;
                dec.sel      = SEL_RW;
                dec.want_off = rng;
                dec.want_dat = 1'b1;
            end
            4'd3: begin
                dec.act      = ACT_EMIT;
                dec.sel      = SEL_RW;
                dec.want_pc  = ~rng;
                dec.want_off = rng;
                dec.want_dat = 1'b1;
            end
            4'd12, 4'd13: begin
                dec.act      = ACT_EMIT;
                dec.sel      = code[0] ? SEL_WR : SEL_RD;
                dec.want_off = rng;
                dec.want_dat = ~rng;
            end
            default: begin
                dec.act      = ACT_EMIT;
                dec.sel      = code[0] ? SEL_WR : SEL_RD;
                dec.want_pc  = ~rng;
                dec.want_off = rng;
                dec.want_dat = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/wcu_mask_cmp.sv
module wcu_mask_cmp #(
    parameter int W  = 32,
    parameter int MW = 4
) (
    input  logic [W-1:0]  lhs,
    input  logic [W-1:0]  rhs,
    input  logic [MW-1:0] ign,
    output logic          eq
);

    logic [W-1:0] keep;

    assign keep = {W{1'b1}} << ign;
    assign eq   = ((lhs ^ rhs) & keep) == '0;

endmodule

// File: rtl/wcu_flag.sv
module wcu_flag
    import wcu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic held
);

    flag_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FLAG_CLEAR;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FLAG_CLEAR: if (set)         state_nx = FLAG_HELD;
            FLAG_HELD:  if (clr && !set) state_nx = FLAG_CLEAR;
            default:                     state_nx = FLAG_CLEAR;
        endcase
    end

    assign held = (state == FLAG_HELD);

endmodule

// File: rtl/watch_cmp_unit.sv
module watch_cmp_unit
    import wcu_pkg::*;
#(
    parameter int NCMP = 4,
    parameter int W    = 32,
    parameter int MW   = 4,
    parameter int FW   = 4,
    parameter int IDXW = 4,
    parameter int OFFW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_instr,
    input  logic              acc_write,
    input  logic [1:0]        acc_size,
    input  logic              acc_fault,
    input  logic              acc_first,
    input  logic [W-1:0]      acc_pc,
    input  logic [W-1:0]      acc_addr,
    input  logic [W-1:0]      acc_data,
    input  logic [W-1:0]      cycle_count,
    input  logic [NCMP*W-1:0] cfg_ref,
    input  logic [NCMP*MW-1:0] cfg_mask,
    input  logic [NCMP*FW-1:0] cfg_func,
    input  logic [NCMP-1:0]   cfg_range,
    input  logic              cfg_cyc_match,
    input  logic              cfg_dv_enable,
    input  logic [1:0]        cfg_dv_size,
    input  logic [IDXW-1:0]   cfg_link_a,
    input  logic [IDXW-1:0]   cfg_link_b,
    input  logic [NCMP-1:0]   flag_rd_clr,
    output logic              watch_req,
    output logic              trig_pulse,
    output logic [NCMP-1:0]   emit_valid,
    output logic [NCMP-1:0]   emit_pc_sel,
    output logic [NCMP-1:0]   emit_addr_sel,
    output logic [NCMP-1:0]   emit_data_sel,
    output logic [W-1:0]      emit_pc,
    output logic [OFFW-1:0]   emit_addr_lo,
    output logic [W-1:0]      emit_data,
    output logic [NCMP-1:0]   matched
);

    localparam int CYC_CMP = 0;
    localparam int DV_CMP  = 1;
    localparam int HALF    = W / 2;

    fdec_t           dec [NCMP];
    logic [NCMP-1:0] deq, peq, ovr, base, wfire, tfire, efire, hit;
    logic [NCMP-1:0] pcf, offf, datf;
    logic            ceq, data_acc, pc_acc, link_hit, val_eq;
    logic [MW-1:0]   size_ign;
    logic [W-1:0]    dv_ref;

    assign size_ign = {{(MW-2){1'b0}}, acc_size};
    assign dv_ref   = cfg_ref[DV_CMP*W +: W];

    // Per-comparator decode and address compares
    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        logic [MW-1:0] mask_i, eff_i;
        assign mask_i = cfg_mask[i*MW +: MW];
        assign eff_i  = (mask_i > size_ign) ? mask_i : size_ign;

        wcu_func_dec #(.FW(FW)) u_dec (
            .code (cfg_func[i*FW +: FW]),
            .rng  (cfg_range[i]),
            .dec  (dec[i])
        );

        wcu_mask_cmp #(.W(W), .MW(MW)) u_dcmp (
            .lhs (acc_addr),
            .rhs (cfg_ref[i*W +: W]),
            .ign (eff_i),
            .eq  (deq[i])
        );

        wcu_mask_cmp #(.W(W), .MW(MW)) u_pcmp (
            .lhs (acc_pc),
            .rhs (cfg_ref[i*W +: W]),
            .ign (mask_i),
            .eq  (peq[i])
        );

        wcu_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (hit[i]),
            .clr   (flag_rd_clr[i]),
            .held  (matched[i])
        );
    end

    wcu_mask_cmp #(.W(W), .MW(MW)) u_ccmp (
        .lhs (cycle_count),
        .rhs (cfg_ref[CYC_CMP*W +: W]),
        .ign (cfg_mask[CYC_CMP*MW +: MW]),
        .eq  (ceq)
    );

    // Link decode and data-value compare
    always_comb begin
        data_acc = acc_valid & ~acc_instr;
        pc_acc   = acc_valid & acc_instr;
        link_hit = 1'b0;
        ovr      = '0;
        for (int j = 0; j < NCMP; j++) begin
            if (j != DV_CMP && (int'(cfg_link_a) == j || int'(cfg_link_b) == j)) begin
                ovr[j]   = cfg_dv_enable;
                link_hit = link_hit | deq[j];
            end
        end
        case (cfg_dv_size)
            2'd0:    val_eq = (acc_data[7:0] == dv_ref[7:0]);
            2'd1:    val_eq = (acc_data[HALF-1:0] == dv_ref[HALF-1:0]);
            default: val_eq = (acc_data == dv_ref);
        endcase
    end

    // Firing decision per comparator
    always_comb begin
        for (int i = 0; i < NCMP; i++) begin
            logic dir_ok;
            dir_ok = (dec[i].sel == SEL_RW) ||
                     (dec[i].sel == SEL_RD && !acc_write) ||
                     (dec[i].sel == SEL_WR &&  acc_write);
            if (i == CYC_CMP && cfg_cyc_match)
                base[i] = ceq && (dec[i].act == ACT_WATCH || dec[i].act == ACT_TRIG);
            else if (i == DV_CMP && cfg_dv_enable)
                base[i] = data_acc && !acc_fault && link_hit && val_eq && dir_ok &&
                          dec[i].act != ACT_NONE && dec[i].sel != SEL_PC;
            else if (ovr[i])
                base[i] = 1'b0;
            else if (dec[i].act == ACT_NONE)
                base[i] = 1'b0;
            else if (dec[i].sel == SEL_PC)
                base[i] = pc_acc && peq[i];
            else
                base[i] = data_acc && deq[i] && dir_ok;

            pcf[i]   = dec[i].want_pc && acc_first;
            offf[i]  = dec[i].want_off;
            datf[i]  = dec[i].want_dat && !acc_fault;
            wfire[i] = base[i] && dec[i].act == ACT_WATCH;
            tfire[i] = base[i] && dec[i].act == ACT_TRIG;
            efire[i] = base[i] && dec[i].act == ACT_EMIT && (pcf[i] || offf[i] || datf[i]);
            hit[i]   = wfire[i] || tfire[i] || efire[i];
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            watch_req     <= 1'b0;
            trig_pulse    <= 1'b0;
            emit_valid    <= '0;
            emit_pc_sel   <= '0;
            emit_addr_sel <= '0;
            emit_data_sel <= '0;
            emit_pc       <= '0;
            emit_addr_lo  <= '0;
            emit_data     <= '0;
        end else begin
            watch_req     <= |wfire;
            trig_pulse    <= |tfire;
            emit_valid    <= efire;
            emit_pc_sel   <= efire & pcf;
            emit_addr_sel <= efire & offf;
            emit_data_sel <= efire & datf;
            if (acc_valid) begin
                emit_pc      <= acc_pc;
                emit_addr_lo <= acc_addr[OFFW-1:0];
                emit_data    <= acc_data;
            end
        end
    end

endmodule

// File: rtl/watch_cmp_unit_chk.sv
module watch_cmp_unit_chk #(
    parameter int NCMP = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_fault,
    input logic              cfg_cyc_match,
    input logic              cfg_dv_enable,
    input logic [4*NCMP-1:0] cfg_func,
    input logic [NCMP-1:0]   flag_rd_clr,
    input logic              watch_req,
    input logic              trig_pulse,
    input logic [NCMP-1:0]   emit_valid,
    input logic [NCMP-1:0]   emit_pc_sel,
    input logic [NCMP-1:0]   emit_addr_sel,
    input logic [NCMP-1:0]   emit_data_sel,
    input logic [NCMP-1:0]   matched
);

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(matched) & ~$past(flag_rd_clr)) & ~matched) == '0));

    p_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(acc_valid) && !$past(cfg_cyc_match)) |->
        (!watch_req && !trig_pulse && emit_valid == '0 && (matched & ~$past(matched)) == '0));

    p_sel_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((emit_pc_sel | emit_addr_sel | emit_data_sel) & ~emit_valid) == '0);

    p_valid_has_payload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_valid & ~(emit_pc_sel | emit_addr_sel | emit_data_sel)) == '0);

    p_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_func[4*NCMP-1 -: 4]) == 4'd0) |->
        (!emit_valid[NCMP-1] && !(matched[NCMP-1] && !$past(matched[NCMP-1]))));

    p_dv_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(acc_fault) && $past(cfg_dv_enable)) |->
        !(matched[1] && !$past(matched[1])));

endmodule

bind watch_cmp_unit watch_cmp_unit_chk #(.NCMP(NCMP)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (acc_valid),
    .acc_fault     (acc_fault),
    .cfg_cyc_match (cfg_cyc_match),
    .cfg_dv_enable (cfg_dv_enable),
    .cfg_func      (cfg_func),
    .flag_rd_clr   (flag_rd_clr),
    .watch_req     (watch_req),
    .trig_pulse    (trig_pulse),
    .emit_valid    (emit_valid),
    .emit_pc_sel   (emit_pc_sel),
    .emit_addr_sel (emit_addr_sel),
    .emit_data_sel (emit_data_sel),
    .matched       (matched)
);

// File: tb/watch_cmp_unit_test.sv
module watch_cmp_unit_test;

    logic clk = 1'b0;
    logic rst_n;
    logic acc_valid, acc_instr, acc_write, acc_fault, acc_first;
    logic [1:0]  acc_size;
    logic [31:0] acc_pc, acc_addr, acc_data, cycle_count;
    logic [127:0] cfg_ref;
    logic [15:0] cfg_mask, cfg_func;
    logic [3:0]  cfg_range;
    logic cfg_cyc_match, cfg_dv_enable;
    logic [1:0] cfg_dv_size;
    logic [3:0] cfg_link_a, cfg_link_b, flag_rd_clr;

    logic watch_req, trig_pulse;
    logic [3:0] emit_valid, emit_pc_sel, emit_addr_sel, emit_data_sel, matched;
    logic [31:0] emit_pc, emit_data;
    logic [15:0] emit_addr_lo;

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R1 reset";

    bit e_watch, e_trig;
    bit [3:0] e_ev, e_ps, e_os, e_ds, e_m;
    bit [31:0] e_pc, e_dat;
    bit [15:0] e_off;

    watch_cmp_unit uut (.*);

    always #4 clk = ~clk;

    task automatic chk(string f, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h exp %h", tag, f, got, exp);
        end
    endtask

    task automatic compare_all();
        chk("watch_req", 32'(watch_req), 32'(e_watch));
        chk("trig_pulse", 32'(trig_pulse), 32'(e_trig));
        chk("emit_valid", 32'(emit_valid), 32'(e_ev));
        chk("emit_pc_sel", 32'(emit_pc_sel), 32'(e_ps));
        chk("emit_addr_sel", 32'(emit_addr_sel), 32'(e_os));
        chk("emit_data_sel", 32'(emit_data_sel), 32'(e_ds));
        chk("emit_pc", emit_pc, e_pc);
        chk("emit_addr_lo", 32'(emit_addr_lo), 32'(e_off));
        chk("emit_data", emit_data, e_dat);
        chk("matched", 32'(matched), 32'(e_m));
    endtask

    // Behavioural reference, applied to the inputs held during this cycle
    task automatic model_step();
        bit [3:0] am, hitv, evv, psv, osv, dsv;
        bit w, t, lhit;
        int la, lb;
        w = 0; t = 0; hitv = 0; evv = 0; psv = 0; osv = 0; dsv = 0;
        if (!rst_n) begin
            e_watch = 0; e_trig = 0; e_ev = 0; e_ps = 0; e_os = 0; e_ds = 0;
            e_m = 0; e_pc = 0; e_dat = 0; e_off = 0;
            return;
        end
        for (int k = 0; k < 4; k++) begin
            int sh;
            logic [31:0] r;
            r  = cfg_ref[k*32 +: 32];
            sh = (int'(cfg_mask[k*4 +: 4]) > int'(acc_size)) ? int'(cfg_mask[k*4 +: 4]) : int'(acc_size);
            am[k] = acc_valid && !acc_instr && ((acc_addr >> sh) == (r >> sh));
        end
        la = int'(cfg_link_a);
        lb = int'(cfg_link_b);
        lhit = (la < 4 && la != 1 && am[la % 4]) || (lb < 4 && lb != 1 && am[lb % 4]);
        for (int k = 0; k < 4; k++) begin
            int code, kind, cls, m;
            bit rng, wp, wo, wd, dir_ok, fires, linked, vm;
            logic [31:0] r;
            r = cfg_ref[k*32 +: 32];
            m = int'(cfg_mask[k*4 +: 4]);
            code = int'(cfg_func[k*4 +: 4]);
            rng = cfg_range[k];
            kind = 0; cls = 0; wp = 0; wo = 0; wd = 0; fires = 0;
            if (code >= 4 && code <= 7) begin kind = 1; cls = code - 4; end
            else if (code >= 8 && code <= 11) begin kind = 2; cls = code - 8; end
            else if (code != 0) begin
                kind = 3;
                case (code)
                    1: begin cls = 3; wp = !rng; wo = rng; end
                    2: begin cls = 3; wo = rng; wd = 1; end
                    3: begin cls = 3; wp = !rng; wo = rng; wd = 1; end
                    12, 13: begin cls = (code == 12) ? 1 : 2; wo = rng; wd = !rng; end
                    default: begin cls = (code == 14) ? 1 : 2; wp = !rng; wo = rng; wd = 1; end
                endcase
            end
            dir_ok = (cls == 3) || (cls == 1 && !acc_write) || (cls == 2 && acc_write);
            linked = cfg_dv_enable && k != 1 && (la == k || lb == k);
            case (cfg_dv_size)
                2'd0: vm = (acc_data[7:0] == r[7:0]);
                2'd1: vm = (acc_data[15:0] == r[15:0]);
                default: vm = (acc_data == r);
            endcase
            if (k == 0 && cfg_cyc_match)
                fires = (kind == 1 || kind == 2) && ((cycle_count >> m) == (r >> m));
            else if (k == 1 && cfg_dv_enable)
                fires = kind != 0 && cls != 0 && dir_ok && acc_valid && !acc_instr &&
                        !acc_fault && lhit && vm;
            else if (linked || kind == 0)
                fires = 0;
            else if (cls == 0)
                fires = acc_valid && acc_instr && ((acc_pc >> m) == (r >> m));
            else
                fires = am[k] && dir_ok;
            if (fires) begin
                if (kind == 1) begin w = 1; hitv[k] = 1; end
                if (kind == 2) begin t = 1; hitv[k] = 1; end
                if (kind == 3) begin
                    bit p, d;
                    p = wp && acc_first;
                    d = wd && !acc_fault;
                    if (p || wo || d) begin
                        evv[k] = 1; psv[k] = p; osv[k] = wo; dsv[k] = d; hitv[k] = 1;
                    end
                end
            end
        end
        e_watch = w; e_trig = t; e_ev = evv; e_ps = psv; e_os = osv; e_ds = dsv;
        e_m = hitv | (e_m & ~flag_rd_clr);
        if (acc_valid) begin
            e_pc = acc_pc; e_off = acc_addr[15:0]; e_dat = acc_data;
        end
    endtask

    task automatic tick();
        compare_all();
        model_step();
        @(negedge clk);
    endtask

    task automatic set_cmp(int k, logic [31:0] r, int m, int f, bit rg);
        cfg_ref[k*32 +: 32] = r;
        cfg_mask[k*4 +: 4]  = 4'(m);
        cfg_func[k*4 +: 4]  = 4'(f);
        cfg_range[k]        = rg;
    endtask

    task automatic clear_cfg();
        cfg_ref = '0; cfg_mask = '0; cfg_func = '0; cfg_range = '0;
        cfg_cyc_match = 0; cfg_dv_enable = 0; cfg_dv_size = 0;
        cfg_link_a = 4'hF; cfg_link_b = 4'hF;
    endtask

    task automatic dacc(logic [31:0] a, bit wr, int sz, logic [31:0] d, bit flt, bit first);
        acc_valid = 1; acc_instr = 0; acc_addr = a; acc_write = wr;
        acc_size = 2'(sz); acc_data = d; acc_fault = flt; acc_first = first;
        acc_pc = 32'h0000_8000 ^ a;
        tick();
        acc_valid = 0; flag_rd_clr = 0;
    endtask

    task automatic iacc(logic [31:0] pc);
        acc_valid = 1; acc_instr = 1; acc_pc = pc; acc_addr = 32'hFFFF_0000; acc_first = 1;
        tick();
        acc_valid = 0; flag_rd_clr = 0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hung run exp completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 0; acc_valid = 0; acc_instr = 0; acc_write = 0; acc_fault = 0;
        acc_first = 1; acc_size = 0; acc_pc = 0; acc_addr = 0; acc_data = 0;
        cycle_count = 0; flag_rd_clr = 0;
        clear_cfg();
        e_m = 0;
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1;
        tick(); tick();

        tag = "R2 masked address";
        set_cmp(2, 32'h103, 0, 7, 0);
        dacc(32'h100, 0, 2, 32'h1, 0, 1);
        dacc(32'h100, 1, 0, 32'h2, 0, 1);
        dacc(32'h103, 1, 0, 32'h3, 0, 1);
        set_cmp(2, 32'h2000, 4, 7, 0);
        dacc(32'h200C, 0, 0, 32'h4, 0, 1);
        dacc(32'h2010, 0, 0, 32'h5, 0, 1);
        tick();

        tag = "R3 watch codes";
        clear_cfg();
        set_cmp(3, 32'h400, 0, 5, 0);
        dacc(32'h400, 1, 2, 0, 0, 1);
        dacc(32'h400, 0, 2, 0, 0, 1);
        set_cmp(3, 32'h400, 0, 6, 0);
        dacc(32'h400, 1, 2, 0, 0, 1);
        set_cmp(3, 32'h800, 2, 4, 0);
        iacc(32'h802);
        iacc(32'h804);
        dacc(32'h800, 0, 2, 0, 0, 1);

        tag = "R4 trigger codes";
        clear_cfg();
        for (int c = 8; c < 12; c++) begin
            set_cmp(2, 32'h600, 0, c, 0);
            iacc(32'h600);
            dacc(32'h600, 0, 2, 0, 0, 1);
            dacc(32'h600, 1, 2, 0, 0, 1);
        end

        tag = "R5 emit codes";
        clear_cfg();
        for (int c = 1; c < 16; c++) begin
            if (c == 4) c = 12;
            set_cmp(3, 32'h700, 0, c, 0);
            dacc(32'h700, 0, 2, 32'hAAAA_0000 + 32'(c), 0, 1);
            dacc(32'h700, 1, 2, 32'hBBBB_0000 + 32'(c), 0, 1);
        end

        tag = "R6 emit range";
        for (int c = 1; c < 16; c++) begin
            if (c == 4) c = 12;
            set_cmp(3, 32'h1700, 0, c, 1);
            dacc(32'h1700, 0, 2, 32'hCCCC_0000 + 32'(c), 0, 1);
            dacc(32'h1700, 1, 2, 32'hDDDD_0000 + 32'(c), 0, 1);
        end

        tag = "R7 fault and burst";
        set_cmp(3, 32'h900, 0, 3, 0);
        dacc(32'h900, 0, 2, 32'h11, 1, 1);
        dacc(32'h900, 0, 2, 32'h12, 0, 0);
        dacc(32'h900, 0, 2, 32'h13, 1, 0);
        set_cmp(3, 32'h900, 0, 12, 0);
        dacc(32'h900, 0, 2, 32'h14, 1, 1);
        set_cmp(3, 32'h900, 0, 1, 0);
        dacc(32'h900, 0, 2, 32'h15, 0, 0);

        tag = "R8 matched flag";
        clear_cfg();
        set_cmp(2, 32'hA00, 0, 7, 0);
        dacc(32'hA00, 0, 2, 0, 0, 1);
        tick(); tick();
        flag_rd_clr = 4'b0100; tick(); flag_rd_clr = 0; tick();
        dacc(32'hA00, 0, 2, 0, 0, 1);
        flag_rd_clr = 4'b0100; dacc(32'hA00, 1, 2, 0, 0, 1);
        tick();
        flag_rd_clr = 4'b0100; tick(); flag_rd_clr = 0; tick();

        tag = "R9 cycle match";
        clear_cfg();
        cfg_cyc_match = 1;
        set_cmp(0, 32'd1000, 0, 4, 0);
        for (int n = 995; n < 1004; n++) begin cycle_count = 32'(n); tick(); end
        set_cmp(0, 32'd1000, 2, 9, 0);
        for (int n = 995; n < 1006; n++) begin cycle_count = 32'(n); tick(); end
        set_cmp(0, 32'd1000, 0, 2, 0);
        cycle_count = 32'd1000; tick(); tick();

        tag = "R10 data value";
        clear_cfg();
        cfg_dv_enable = 1; cfg_link_a = 4'd2; cfg_link_b = 4'd3;
        set_cmp(1, 32'h1234_5678, 0, 7, 0);
        set_cmp(2, 32'hB00, 0, 7, 0);
        set_cmp(3, 32'hC00, 0, 4, 0);
        for (int s = 0; s < 4; s++) begin
            cfg_dv_size = 2'(s);
            dacc(32'hB00, 1, 2, 32'h1234_5678, 0, 1);
            dacc(32'hB00, 1, 2, 32'h9999_5678, 0, 1);
            dacc(32'hB00, 1, 2, 32'h9999_9978, 0, 1);
            dacc(32'hC00, 0, 2, 32'h1234_5678, 0, 1);
            dacc(32'hD00, 0, 2, 32'h1234_5678, 0, 1);
            dacc(32'hB00, 0, 2, 32'h1234_5678, 1, 1);
        end
        cfg_link_a = 4'd1; cfg_link_b = 4'd9;
        dacc(32'hB00, 0, 2, 32'h1234_5678, 0, 1);

        tag = "R11 linked override";
        cfg_link_a = 4'd2; cfg_link_b = 4'd3;
        flag_rd_clr = 4'hF; tick(); flag_rd_clr = 0;
        dacc(32'hB00, 0, 2, 32'h0, 0, 1);
        iacc(32'hC00);
        cfg_dv_enable = 0;
        iacc(32'hC00);
        tick();

        tag = "R12 disabled";
        clear_cfg();
        flag_rd_clr = 4'hF; tick(); flag_rd_clr = 0;
        dacc(32'h0, 0, 2, 0, 0, 1);
        iacc(32'h0);
        dacc(32'h0, 1, 0, 0, 1, 0);

        tag = "R13 no strobe";
        set_cmp(2, 32'hE00, 0, 7, 0);
        acc_addr = 32'hE00; acc_instr = 0; acc_valid = 0; tick(); tick();
        dacc(32'hE00, 0, 2, 0, 0, 1);
        tick();

        tag = "R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 R13 mixed traffic";
        for (int n = 0; n < 2000; n++) begin
            if (n % 64 == 0) begin
                for (int k = 0; k < 4; k++)
                    set_cmp(k, 32'h100 + $urandom_range(0, 63), $urandom_range(0, 5),
                            $urandom_range(0, 15), 1'($urandom_range(0, 1)));
                cfg_cyc_match = ($urandom_range(0, 3) == 0);
                if (cfg_cyc_match) cfg_ref[31:0] = cycle_count + $urandom_range(0, 60);
                cfg_dv_enable = ($urandom_range(0, 2) == 0);
                cfg_dv_size = 2'($urandom_range(0, 3));
                cfg_link_a = 4'($urandom_range(0, 5));
                cfg_link_b = 4'($urandom_range(0, 5));
            end
            acc_valid = ($urandom_range(0, 3) != 0);
            acc_instr = ($urandom_range(0, 3) == 0);
            acc_pc    = 32'h100 + $urandom_range(0, 63);
            acc_addr  = 32'h100 + $urandom_range(0, 63);
            acc_write = 1'($urandom_range(0, 1));
            acc_size  = 2'($urandom_range(0, 2));
            acc_fault = ($urandom_range(0, 4) == 0);
            acc_first = ($urandom_range(0, 2) != 0);
            case ($urandom_range(0, 3))
                0: acc_data = cfg_ref[63:32];
                1: acc_data = cfg_ref[63:32] ^ 32'h0001_0000;
                2: acc_data = cfg_ref[63:32] ^ 32'h0000_0100;
                default: acc_data = $urandom;
            endcase
            flag_rd_clr = 4'($urandom_range(0, 15) & $urandom_range(0, 15) & $urandom_range(0, 15));
            tick();
            cycle_count = cycle_count + 1;
        end
        acc_valid = 0; flag_rd_clr = 0;
        tick();

        summary();
        $finish;
    end

endmodule